// File: doc/BRIEF.md
# Write-Protected Self-Timing Prescaler

This block divides the oscillator clock down to a fixed-period timing tick for the program and erase sequencer of a nonvolatile memory. A 10-bit divide value sits in two byte-wide registers on a small register bus. It is chosen so that one tick spans roughly 35 µs (±2 µs): the value is the oscillator frequency times 35e-6, plus one half, rounded down. While an operation is active the counter runs from 0 up to the divide value minus one and pulses the tick output once per wrap.

The divide value is not reset to a constant. On reset both registers copy a nonvolatile shadow word. Software may then change the value, subject to two gates. A latch-control input must be clear. In normal mode each byte takes only one write per reset, while special mode allows any number of writes. A divide value of zero blocks program and erase entirely: the permit output is low and no tick is produced.

Top module: `nvm_tick_prescaler`

## Requirements
- R1: While `rst` is high at a clock edge, the divide value is loaded from `shadow_word`. The write-once flags are cleared and the counter and `tick` are cleared.
- R2: With `bus_sel` high, `bus_rdata` is combinational. Address 0 returns bits 7:0 of the divide value. Address 1 returns bits 9:8 in bit positions 1:0, with bits 7:2 as 0. With `bus_sel` low, `bus_rdata` is 0. Reads never change state.
- R3: In normal mode (`special_mode`=0) with `latch_on`=0, the first write to each byte after reset is taken. Any later write to that byte is refused and leaves it unchanged.
- R4: In special mode (`special_mode`=1) with `latch_on`=0, every write is taken. Special-mode writes do not use up a byte's single normal-mode write.
- R5: With `latch_on`=1, every write is refused in both modes. A refused write does not use up the normal-mode write of that byte.
- R6: A write to address 1 stores only `bus_wdata[1:0]`, as bits 9:8.
- R7: While `op_active`=1 and the divide value D is not 0, `tick` is high for exactly one cycle out of every D cycles. The first pulse follows the D-th clock edge after `op_active` is first sampled high. When D=1, `tick` stays high.
- R8: While `op_active`=0, the counter is held at 0 and `tick` is low.
- R9: `op_permit` is high exactly when the divide value is not 0. When the divide value is 0, `tick` never pulses.
- R10: An accepted write restarts the count from 0 at the write edge. The next pulse follows the new D-th edge after it.
- R11: Changes of `special_mode` or `latch_on` without an accepted write never alter the divide value or the tick spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write enable (with `bus_sel`) |
| bus_addr | input | 1 | Byte select: 0 low byte, 1 high byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| special_mode | input | 1 | 1 = special mode (writes unlimited), 0 = normal mode (write once) |
| latch_on | input | 1 | 1 blocks all divider writes |
| shadow_word | input | 10 | Nonvolatile reset value of the divide value |
| op_active | input | 1 | A program/erase operation is running |
| tick | output | 1 | One-cycle self-timing pulse |
| op_permit | output | 1 | Divide value is nonzero, so operations may start |

## Verification
The assertions take for granted that `rst` is high for at least one edge before any check matters. They also assume that `shadow_word` only matters during reset, and that the bus inputs are steady around each clock edge. The stimulus keeps to this. It drives every input on the falling edge and holds `shadow_word` constant across each reset pulse. It toggles mode and latch only in cycles with no bus write pending, so that the checks on write gating and on the stability of the divide value see each bus command in isolation.

// File: rtl/nvt_pkg.sv
package nvt_pkg;

    localparam int DIV_W     = 10;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = (DIV_W + BYTE_W - 1) / BYTE_W;
    localparam int ADDR_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

    typedef logic [DIV_W-1:0]  div_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [0:0] {
        MODE_NORMAL  = 1'b0,
        MODE_SPECIAL = 1'b1
    } op_mode_e;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        byte_t             data;
    } bus_cmd_t;

    // width of byte lane b inside the divide value
    function automatic int lane_width(int b);
        int rem;
        rem = DIV_W - b * BYTE_W;
        return (rem < BYTE_W) ? rem : BYTE_W;
    endfunction

    // a byte lane accepts a write when unlatched and either special or unused
    function automatic logic lane_may_write(op_mode_e mode, logic latched, logic used);
        return !latched && ((mode == MODE_SPECIAL) || !used);
    endfunction

endpackage

// File: rtl/nvt_div_reg.sv
module nvt_div_reg
    import nvt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_cmd_t cmd,
    input  op_mode_e mode,
    input  logic     latch_on,
    input  div_t     shadow_word,
    output div_t     div_q,
    output byte_t    rdata,
    output logic     reload
);

    logic  [NUM_BYTES-1:0] lane_acc;
    byte_t                 lane_rd [NUM_BYTES];

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
        localparam int LSB = b * BYTE_W;
        localparam int W   = lane_width(b);

        logic [W-1:0] lane_q;
        logic         once_q;
        logic         hit;
        logic         accept;

        assign hit    = cmd.sel && cmd.wr && (cmd.addr == ADDR_W'(b));
        assign accept = hit && lane_may_write(mode, latch_on, once_q);

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= shadow_word[LSB +: W];
                once_q <= 1'b0;
            end else if (accept) begin
                lane_q <= cmd.data[W-1:0];
                if (mode == MODE_NORMAL) begin
                    once_q <= 1'b1;
                end
            end
        end

        assign div_q[LSB +: W] = lane_q;
        assign lane_acc[b]     = accept;
        assign lane_rd[b]      = BYTE_W'(lane_q);

        // R3
        once_refuse_chk: assert property (@(posedge clk) disable iff (rst)
            (hit && mode == MODE_NORMAL && once_q) |=> $stable(lane_q));

        // R2
        lane_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (cmd.sel && cmd.addr == ADDR_W'(b)) |-> ((rdata >> W) == '0));
    end

    assign reload = |lane_acc;

    always_comb begin
        rdata = '0;
        if (cmd.sel) begin
            rdata = lane_rd[cmd.addr];
        end
    end

    // R5
    latch_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.sel && cmd.wr && latch_on) |=> $stable(div_q));

    // R11
    value_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!reload) |=> $stable(div_q));

endmodule

// File: rtl/nvt_tick_count.sv
module nvt_tick_count
    import nvt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic op_active,
    input  logic reload,
    input  div_t divisor,
    output logic tick
);

    div_t cnt_q;
    logic tick_q;
    logic running;
    logic at_end;

    assign running = op_active && (divisor != '0);
    assign at_end  = (cnt_q == divisor - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !running || reload) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (at_end) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + DIV_W'(1);
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (divisor != '0) |-> (cnt_q < divisor));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_active) |=> (cnt_q == '0 && !tick_q));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        reload |=> (cnt_q == '0 && !tick_q));

endmodule

// File: rtl/nvm_tick_prescaler.sv
module nvm_tick_prescaler
    import nvt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              special_mode,
    input  logic              latch_on,
    input  logic [DIV_W-1:0]  shadow_word,
    input  logic              op_active,
    output logic              tick,
    output logic              op_permit
);

    bus_cmd_t cmd;
    op_mode_e mode;
    div_t     div_val;
    logic     reload;

    assign cmd  = '{sel: bus_sel, wr: bus_wr, addr: bus_addr, data: bus_wdata};
    assign mode = special_mode ? MODE_SPECIAL : MODE_NORMAL;

    nvt_div_reg u_div_reg (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .mode        (mode),
        .latch_on    (latch_on),
        .shadow_word (shadow_word),
        .div_q       (div_val),
        .rdata       (bus_rdata),
        .reload      (reload)
    );

    nvt_tick_count u_tick_count (
        .clk       (clk),
        .rst       (rst),
        .op_active (op_active),
        .reload    (reload),
        .divisor   (div_val),
        .tick      (tick)
    );

    assign op_permit = (div_val != '0);

    // R9
    no_zero_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_permit) |-> !tick);

endmodule

// File: tb/nvm_tick_prescaler_bench.sv
`timescale 1ns/1ps
module nvm_tick_prescaler_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [0:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       special_mode = 1'b0;
    logic       latch_on = 1'b0;
    logic [9:0] shadow_word = '0;
    logic       op_active = 1'b0;
    logic       tick;
    logic       op_permit;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    nvm_tick_prescaler u_nvm_tick_prescaler (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .special_mode(special_mode), .latch_on(latch_on),
        .shadow_word(shadow_word), .op_active(op_active),
        .tick(tick), .op_permit(op_permit)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(logic [9:0] sv);
        @(negedge clk);
        rst = 1'b1; shadow_word = sv; bus_sel = 0; bus_wr = 0;
        special_mode = 0; latch_on = 0; op_active = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_write(logic a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(logic a, output int v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 0;
    endtask

    // next posedge is edge 1; expects a pulse after every d-th edge
    task automatic tick_pattern(string req, int d, int edges, bit wiggle);
        int first_bad;
        first_bad = 0;
        for (int i = 1; i <= edges; i++) begin
            @(negedge clk);
            if (tick != ((i % d) == 0) && first_bad == 0) first_bad = i;
            if (wiggle) begin
                special_mode = ~special_mode;
                latch_on = (i % 3) == 0;
            end
        end
        check(req, first_bad, 0);
    endtask

    task automatic t_reset();
        int v;
        do_reset(10'h2A5);
        bus_read(0, v); check("R1 lo", v, 8'hA5);
        bus_read(1, v); check("R1/R2 hi", v, 8'h02);
        check("R9 permit", op_permit, 1);
        check("R1 tick", tick, 0);
        #1 check("R2 unselected", bus_rdata, 0);
    endtask

    task automatic t_normal_once();
        int v;
        do_reset(10'h2A5);
        bus_write(0, 8'h33); bus_read(0, v); check("R3 first", v, 8'h33);
        bus_write(0, 8'h44); bus_read(0, v); check("R3 second", v, 8'h33);
        bus_write(1, 8'hFF); bus_read(1, v); check("R6 hi mask", v, 8'h03);
        bus_write(1, 8'h01); bus_read(1, v); check("R3 hi second", v, 8'h03);
    endtask

    task automatic t_latch();
        int v;
        do_reset(10'h2A5);
        latch_on = 1;
        bus_write(0, 8'h11); bus_read(0, v); check("R5 normal latched", v, 8'hA5);
        special_mode = 1;
        bus_write(1, 8'h01); bus_read(1, v); check("R5 special latched", v, 8'h02);
        special_mode = 0; latch_on = 0;
        bus_write(0, 8'h11); bus_read(0, v); check("R5 not consumed", v, 8'h11);
    endtask

    task automatic t_special();
        int v;
        do_reset(10'h100);
        special_mode = 1;
        bus_write(0, 8'h10); bus_read(0, v); check("R4 w1", v, 8'h10);
        bus_write(0, 8'h20); bus_read(0, v); check("R4 w2", v, 8'h20);
        bus_write(1, 8'h00); bus_read(1, v); check("R4 hi", v, 0);
        special_mode = 0;
        bus_write(0, 8'h30); bus_read(0, v); check("R4 normal after", v, 8'h30);
    endtask

    task automatic t_tick();
        do_reset(10'd5);
        @(negedge clk); op_active = 1;
        tick_pattern("R7 d=5", 5, 17, 0);
        @(negedge clk); op_active = 0;
        @(negedge clk); check("R8 idle tick", tick, 0);
        repeat (6) @(negedge clk);
        check("R8 idle stays low", tick, 0);
        op_active = 1;
        tick_pattern("R8 restart d=5", 5, 11, 0);
        op_active = 0;
        do_reset(10'd1);
        @(negedge clk); op_active = 1;
        tick_pattern("R7 d=1", 1, 6, 0);
        op_active = 0;
    endtask

    task automatic t_zero();
        int seen;
        do_reset(10'd0);
        check("R9 permit low", op_permit, 0);
        op_active = 1; seen = 0;
        repeat (20) begin @(negedge clk); if (tick) seen++; end
        check("R9 no tick", seen, 0);
        bus_write(0, 8'd3);
        check("R9 permit high", op_permit, 1);
        tick_pattern("R10 from zero d=3", 3, 10, 0);
        op_active = 0;
    endtask

    task automatic t_restart();
        do_reset(10'd6);
        special_mode = 1;
        @(negedge clk); op_active = 1;
        repeat (4) @(negedge clk);
        bus_write(0, 8'd4);
        tick_pattern("R10 restart d=4", 4, 13, 0);
        op_active = 0;
    endtask

    task automatic t_mode_change();
        int v;
        do_reset(10'd7);
        @(negedge clk); op_active = 1;
        tick_pattern("R11 spacing", 7, 22, 1);
        op_active = 0; special_mode = 0; latch_on = 0;
        bus_read(0, v); check("R11 value", v, 7);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_normal_once();
        t_latch();
        t_special();
        t_tick();
        t_zero();
        t_restart();
        t_mode_change();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule